// File: doc/BRIEF.md
# PCS Errored-Seconds Monitor

This block watches the stream of 66-bit blocks that a 10G-class receive path delivers once block alignment and descrambling are done. Every accepted block is sorted by its 2-bit sync header and, for control blocks, by the 8-bit type byte. Two fault classes result. A block whose header is neither the data code nor the control code is a header fault. A control block whose type byte is not a legal code is a format fault. Each fault is reported as a one-cycle strobe.

Line quality is reported per second, not per fault. For each category the block keeps a flag that marks whether the current one-second window saw any fault. At every second tick that flag is turned into at most one increment of a saturating seconds counter, so a storm of faults and a single fault weigh the same. A window in which no block arrived at all, which is what a dead or unplugged far end looks like, is counted as errored in both categories. A separate high bit-error-rate flag is judged over fixed windows of accepted blocks from the number of header faults in each window.

Top module: `pcs_errsec_monitor`

## Requirements
- R1: A block accepted with `blk_valid` high and sync header `blk_data[65:64] == 2'b01` is a data block and raises neither fault strobe.
- R2: An accepted block with `blk_data[65:64]` equal to `2'b00` or `2'b11` raises `hdr_err_o` for exactly the cycle after it is accepted, and never raises `fmt_err_o`.
- R3: An accepted block with header `2'b10` is a control block whose type byte is `blk_data[63:56]`. The legal type codes are 0x1E, 0x2D, 0x33, 0x4B, 0x55, 0x66, 0x78, 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 and 0xFF. Any other type byte raises `fmt_err_o` for the cycle after acceptance, and a legal one raises nothing.
- R4: When `blk_valid` is low, `blk_data` has no effect on the strobes, the seconds counters or the high-BER flag.
- R5: On each `sec_tick`, `hdr_err_secs` rises by exactly one, visible the cycle after the tick, if the window that ends there held one or more header faults, whatever their number. Otherwise it holds.
- R6: On each `sec_tick`, `fmt_err_secs` rises by exactly one in the same way if the ending window held one or more format faults.
- R7: A window that ends at a tick with no accepted block at all counts as errored in both counters. The window that runs from reset to the first tick is such a window if it holds no blocks.
- R8: A block accepted in the same cycle as `sec_tick` belongs to the window that starts at that tick.
- R9: Each counter is CNT_W bits wide, stops at 2^CNT_W-1 and stays there until cleared.
- R10: `err_clear` zeroes both counters in the following cycle and takes priority over an increment from a simultaneous tick.
- R11: Accepted blocks are grouped into consecutive windows of BER_WIN blocks counted from reset. At the end of each window, `hi_ber_o` is set if the window held BER_THRESH or more header faults and cleared otherwise. The new value is visible the cycle after the window's last block.
- R12: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_valid | input | 1 | Qualifies `blk_data` for this cycle |
| blk_data | input | 66 | Aligned block: header in [65:64], payload in [63:0] |
| sec_tick | input | 1 | One-cycle pulse that ends a one-second window |
| err_clear | input | 1 | Synchronous clear of both seconds counters |
| hdr_err_o | output | 1 | Header-fault strobe, one cycle after the block |
| fmt_err_o | output | 1 | Format-fault strobe, one cycle after the block |
| hi_ber_o | output | 1 | High bit-error-rate status |
| hdr_err_secs | output | CNT_W | Seconds holding at least one header fault |
| fmt_err_secs | output | CNT_W | Seconds holding at least one format fault |

## Verification
The bench builds the block with CNT_W = 4, BER_WIN = 8 and BER_THRESH = 3. A 4-bit counter saturates after fifteen errored windows, so the sticking point is reached and held within a few hundred cycles. An 8-block BER window with a threshold of three lets random header faults drive `hi_ber_o` both up and down many times. Because ticks arrive every few dozen cycles, the run covers empty windows, faults that land on the tick cycle, and clears that coincide with ticks.

// File: rtl/pcs_esm_pkg.sv
package pcs_esm_pkg;

  localparam logic [1:0] SH_DATA = 2'b01;
  localparam logic [1:0] SH_CTRL = 2'b10;

  localparam int unsigned NUM_CAT = 2;
  localparam int unsigned CAT_HDR = 0;
  localparam int unsigned CAT_FMT = 1;

  typedef enum logic [1:0] {
    KIND_DATA   = 2'd0,
    KIND_CTRL   = 2'd1,
    KIND_BADHDR = 2'd2,
    KIND_BADFMT = 2'd3
  } blk_kind_e;

  function automatic logic type_is_legal(input logic [7:0] t);
    logic ok;
    case (t)
      8'h1E, 8'h2D, 8'h33, 8'h4B, 8'h55,
      8'h66, 8'h78, 8'h87, 8'h99, 8'hAA,
      8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF: ok = 1'b1;
      default:                           ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/pcs_esm_classify.sv
module pcs_esm_classify
  import pcs_esm_pkg::*;
#(
  parameter int unsigned BLK_W = 66
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_valid,
  input  logic [BLK_W-1:0] blk_data,
  output logic             hdr_fault_c,
  output logic             fmt_fault_c,
  output logic             hdr_stb_q,
  output logic             fmt_stb_q
);

  localparam int unsigned HDR_HI  = BLK_W - 1;
  localparam int unsigned HDR_LO  = BLK_W - 2;
  localparam int unsigned TYPE_HI = BLK_W - 3;
  localparam int unsigned TYPE_LO = BLK_W - 10;

  logic [1:0] sh;
  logic [7:0] ty;
  blk_kind_e  kind;
  logic       hdr_stb_d;
  logic       fmt_stb_d;

  always_comb begin
    sh = blk_data[HDR_HI:HDR_LO];
    ty = blk_data[TYPE_HI:TYPE_LO];
    if (sh == SH_DATA) begin
      kind = KIND_DATA;
    end else if (sh == SH_CTRL) begin
      kind = type_is_legal(ty) ? KIND_CTRL : KIND_BADFMT;
    end else begin
      kind = KIND_BADHDR;
    end
    hdr_fault_c = blk_valid && (kind == KIND_BADHDR);
    fmt_fault_c = blk_valid && (kind == KIND_BADFMT);
    hdr_stb_d   = hdr_fault_c;
    fmt_stb_d   = fmt_fault_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hdr_stb_q <= 1'b0;
      fmt_stb_q <= 1'b0;
    end else begin
      hdr_stb_q <= hdr_stb_d;
      fmt_stb_q <= fmt_stb_d;
    end
  end

endmodule

// File: rtl/pcs_esm_seccnt.sv
module pcs_esm_seccnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clr,
  input  logic             fault_c,
  input  logic             valid_c,
  output logic [CNT_W-1:0] cnt_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             sticky_q, sticky_d;
  logic             seen_q, seen_d;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             win_bad;

  always_comb begin
    win_bad  = sticky_q || !seen_q;
    sticky_d = sticky_q || fault_c;
    seen_d   = seen_q || valid_c;
    cnt_d    = cnt_q;
    if (tick) begin
      // the block on the tick cycle opens the next window
      sticky_d = fault_c;
      seen_d   = valid_c;
      if (win_bad && (cnt_q != CNT_MAX)) begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (clr) begin
      cnt_d = '0;
    end
    cnt_en = tick || clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= 1'b0;
      seen_q   <= 1'b0;
    end else begin
      sticky_q <= sticky_d;
      seen_q   <= seen_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pcs_esm_ber.sv
module pcs_esm_ber #(
  parameter int unsigned BER_WIN    = 19531,
  parameter int unsigned BER_THRESH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic valid_c,
  input  logic hdr_fault_c,
  output logic hi_ber_q
);

  localparam int unsigned IDX_W = (BER_WIN > 1) ? $clog2(BER_WIN) : 1;
  localparam int unsigned FC_W  = $clog2(BER_WIN + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(BER_WIN - 1);
  localparam logic [FC_W-1:0]  THR      = FC_W'(BER_THRESH);

  logic [IDX_W-1:0] idx_q, idx_d;
  logic [FC_W-1:0]  fcnt_q, fcnt_d;
  logic [FC_W-1:0]  total;
  logic             hi_ber_d;
  logic             last_blk;

  always_comb begin
    total    = fcnt_q + FC_W'(hdr_fault_c);
    last_blk = (idx_q == IDX_LAST);
    idx_d    = idx_q;
    fcnt_d   = fcnt_q;
    hi_ber_d = hi_ber_q;
    if (valid_c) begin
      if (last_blk) begin
        idx_d    = '0;
        fcnt_d   = '0;
        hi_ber_d = (total >= THR);
      end else begin
        idx_d  = idx_q + 1'b1;
        fcnt_d = total;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      fcnt_q   <= '0;
      hi_ber_q <= 1'b0;
    end else if (valid_c) begin
      idx_q    <= idx_d;
      fcnt_q   <= fcnt_d;
      hi_ber_q <= hi_ber_d;
    end
  end

endmodule

// File: rtl/pcs_errsec_monitor.sv
module pcs_errsec_monitor
  import pcs_esm_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned BER_WIN    = 19531,
  parameter int unsigned BER_THRESH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_valid,
  input  logic [65:0]      blk_data,
  input  logic             sec_tick,
  input  logic             err_clear,
  output logic             hdr_err_o,
  output logic             fmt_err_o,
  output logic             hi_ber_o,
  output logic [CNT_W-1:0] hdr_err_secs,
  output logic [CNT_W-1:0] fmt_err_secs
);

  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  logic             hdr_fault_c;
  logic             fmt_fault_c;
  logic [NUM_CAT-1:0] cat_fault;
  logic [CNT_W-1:0] cat_cnt [NUM_CAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  pcs_esm_classify #(.BLK_W(66)) u_classify (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .blk_valid   (blk_valid),
    .blk_data    (blk_data),
    .hdr_fault_c (hdr_fault_c),
    .fmt_fault_c (fmt_fault_c),
    .hdr_stb_q   (hdr_err_o),
    .fmt_stb_q   (fmt_err_o)
  );

  assign cat_fault[CAT_HDR] = hdr_fault_c;
  assign cat_fault[CAT_FMT] = fmt_fault_c;

  for (genvar g = 0; g < NUM_CAT; g++) begin : g_cat
    pcs_esm_seccnt #(.CNT_W(CNT_W)) u_seccnt (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .tick    (sec_tick),
      .clr     (err_clear),
      .fault_c (cat_fault[g]),
      .valid_c (blk_valid),
      .cnt_q   (cat_cnt[g])
    );
  end

  assign hdr_err_secs = cat_cnt[CAT_HDR];
  assign fmt_err_secs = cat_cnt[CAT_FMT];

  pcs_esm_ber #(
    .BER_WIN    (BER_WIN),
    .BER_THRESH (BER_THRESH)
  ) u_ber (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .valid_c     (blk_valid),
    .hdr_fault_c (hdr_fault_c),
    .hi_ber_q    (hi_ber_o)
  );

endmodule

// File: rtl/pcs_esm_checker.sv
module pcs_esm_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             blk_valid,
  input logic [65:0]      blk_data,
  input logic             sec_tick,
  input logic             err_clear,
  input logic             hdr_err_o,
  input logic             fmt_err_o,
  input logic [CNT_W-1:0] hdr_err_secs,
  input logic [CNT_W-1:0] fmt_err_secs
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  p_hdr_strobe_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    (blk_valid && (blk_data[65:64] == 2'b00 || blk_data[65:64] == 2'b11))
      |=> (hdr_err_o && !fmt_err_o));

  p_strobes_excl_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    $countones({hdr_err_o, fmt_err_o}) <= 1);

  p_invalid_quiet_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    !blk_valid |=> (!hdr_err_o && !fmt_err_o));

  p_hdr_step_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    !$stable(hdr_err_secs) |-> (hdr_err_secs == $past(hdr_err_secs) + 1'b1 || hdr_err_secs == '0));

  p_hdr_only_tick_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (!sec_tick && !err_clear) |=> $stable(hdr_err_secs));

  p_fmt_only_tick_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (!sec_tick && !err_clear) |=> $stable(fmt_err_secs));

  p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (hdr_err_secs == CMAX && !err_clear) |=> (hdr_err_secs == CMAX));

  p_clear_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    err_clear |=> (hdr_err_secs == '0 && fmt_err_secs == '0));

endmodule

bind pcs_errsec_monitor pcs_esm_checker #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_ni       (rst_core_n),
  .blk_valid    (blk_valid),
  .blk_data     (blk_data),
  .sec_tick     (sec_tick),
  .err_clear    (err_clear),
  .hdr_err_o    (hdr_err_o),
  .fmt_err_o    (fmt_err_o),
  .hdr_err_secs (hdr_err_secs),
  .fmt_err_secs (fmt_err_secs)
);

// File: tb/pcs_errsec_monitor_bench.sv
module pcs_errsec_monitor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 4;
  localparam int BER_WIN    = 8;
  localparam int BER_THRESH = 3;
  localparam int CMAX       = (1 << CNT_W) - 1;

  logic             clk;
  logic             rst_n;
  logic             blk_valid;
  logic [65:0]      blk_data;
  logic             sec_tick;
  logic             err_clear;
  logic             hdr_err_o;
  logic             fmt_err_o;
  logic             hi_ber_o;
  logic [CNT_W-1:0] hdr_err_secs;
  logic [CNT_W-1:0] fmt_err_secs;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  // reference state, reflecting the outputs after the most recent edge
  int m_hs, m_fs, m_hb, m_ch, m_cf;
  int m_stk_h, m_stk_f, m_seen, m_idx, m_fc;

  pcs_errsec_monitor #(
    .CNT_W(CNT_W), .BER_WIN(BER_WIN), .BER_THRESH(BER_THRESH)
  ) u_pcs_errsec_monitor (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_data(blk_data),
    .sec_tick(sec_tick), .err_clear(err_clear), .hdr_err_o(hdr_err_o),
    .fmt_err_o(fmt_err_o), .hi_ber_o(hi_ber_o),
    .hdr_err_secs(hdr_err_secs), .fmt_err_secs(fmt_err_secs)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic bit legal_code(input logic [7:0] t);
    logic [7:0] codes [15] = '{8'hFF, 8'hE1, 8'hD2, 8'hCC, 8'hB4, 8'hAA, 8'h99,
                               8'h87, 8'h78, 8'h66, 8'h55, 8'h4B, 8'h33, 8'h2D, 8'h1E};
    for (int i = 0; i < 15; i++) if (codes[i] == t) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] pick_code(input int i);
    logic [7:0] codes [15] = '{8'h1E, 8'h2D, 8'h33, 8'h4B, 8'h55, 8'h66, 8'h78,
                               8'h87, 8'h99, 8'hAA, 8'hB4, 8'hCC, 8'hD2, 8'hE1, 8'hFF};
    return codes[i % 15];
  endfunction

  function automatic logic [65:0] mk(input logic [1:0] sh, input logic [7:0] ty);
    return {sh, ty, 24'($urandom), 32'($urandom)};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 header strobe", int'(hdr_err_o), m_hs);
    chk("R3 format strobe", int'(fmt_err_o), m_fs);
    chk("R11 high-BER flag", int'(hi_ber_o), m_hb);
    chk("R5 header seconds", int'(hdr_err_secs), m_ch);
    chk("R6 format seconds", int'(fmt_err_secs), m_cf);
  endtask

  // drive one cycle (called at a negedge), advance the reference, compare after the edge
  task automatic step(input bit v, input logic [65:0] d, input bit tk, input bit cl);
    int hf, ff;
    blk_valid = v; blk_data = d; sec_tick = tk; err_clear = cl;
    hf = (v && (d[65:64] == 2'b00 || d[65:64] == 2'b11)) ? 1 : 0;
    ff = (v && d[65:64] == 2'b10 && !legal_code(d[63:56])) ? 1 : 0;
    m_hs = hf; m_fs = ff;
    if (tk) begin
      if ((m_stk_h || !m_seen) && m_ch < CMAX) m_ch++;
      if ((m_stk_f || !m_seen) && m_cf < CMAX) m_cf++;
      m_stk_h = hf; m_stk_f = ff; m_seen = v;
    end else begin
      m_stk_h |= hf; m_stk_f |= ff; m_seen |= v;
    end
    if (cl) begin m_ch = 0; m_cf = 0; end
    if (v) begin
      if (m_idx == BER_WIN - 1) begin
        m_hb = ((m_fc + hf) >= BER_THRESH) ? 1 : 0;
        m_idx = 0; m_fc = 0;
      end else begin
        m_idx++; m_fc += hf;
      end
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 66'h0, 1'b0, 1'b0);
  endtask

  task automatic good(input int n);
    for (int i = 0; i < n; i++) step(1'b1, mk(2'b01, 8'($urandom)), 1'b0, 1'b0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        fails++; checks++;
        $display("FAIL R12 watchdog: actual %0d cycles expected under 100000", cycles);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  initial begin
    int base;
    void'($urandom(32'd20161021));
    m_hs = 0; m_fs = 0; m_hb = 0; m_ch = 0; m_cf = 0;
    m_stk_h = 0; m_stk_f = 0; m_seen = 0; m_idx = 0; m_fc = 0;
    rst_n = 1'b0; blk_valid = 1'b0; blk_data = '0; sec_tick = 1'b0; err_clear = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12: reset state
    compare_all();
    chk("R12 reset counters", int'(hdr_err_secs) + int'(fmt_err_secs), 0);

    // R1: data header raises nothing
    step(1'b1, mk(2'b01, 8'h00), 1'b0, 1'b0);
    chk("R1 data block quiet", int'(hdr_err_o) + int'(fmt_err_o), 0);

    // R3: legal and illegal control types
    step(1'b1, mk(2'b10, 8'h78), 1'b0, 1'b0);
    chk("R3 legal type quiet", int'(fmt_err_o), 0);
    step(1'b1, mk(2'b10, 8'h7F), 1'b0, 1'b0);
    chk("R3 illegal type flagged", int'(fmt_err_o), 1);

    // R2: both bad header codes
    step(1'b1, mk(2'b00, 8'h1E), 1'b0, 1'b0);
    chk("R2 header 00 flagged", int'(hdr_err_o), 1);
    step(1'b1, mk(2'b11, 8'h1E), 1'b0, 1'b0);
    chk("R2 header 11 flagged", int'(hdr_err_o), 1);

    // R4: invalid cycles carrying faulty data change nothing
    step(1'b0, mk(2'b11, 8'h00), 1'b0, 1'b0);
    chk("R4 invalid quiet", int'(hdr_err_o) + int'(fmt_err_o), 0);
    good(3);
    step(1'b0, mk(2'b10, 8'h01), 1'b1, 1'b0);
    // window had header and format faults: both +1
    chk("R5 first window counted", int'(hdr_err_secs), 1);
    chk("R6 first window counted", int'(fmt_err_secs), 1);

    // R4/R5: next window: only invalid faulty data plus good blocks
    good(4);
    step(1'b0, mk(2'b00, 8'h00), 1'b0, 1'b0);
    step(1'b1, mk(2'b01, 8'h00), 1'b1, 1'b0);
    chk("R4 invalid data not counted", int'(hdr_err_secs), 1);

    // R8: fault on tick cycle lands in new window (previous tick carried good block)
    good(2);
    step(1'b1, mk(2'b00, 8'h00), 1'b1, 1'b0);
    chk("R8 tick-cycle fault not in old window", int'(hdr_err_secs), 1);
    good(3);
    step(1'b1, mk(2'b01, 8'h00), 1'b1, 1'b0);
    chk("R8 tick-cycle fault in new window", int'(hdr_err_secs), 2);

    // R5: many faults in one window give one increment
    for (int i = 0; i < 6; i++) step(1'b1, mk(2'b11, 8'h00), 1'b0, 1'b0);
    step(1'b1, mk(2'b01, 8'h00), 1'b1, 1'b0);
    chk("R5 one per window", int'(hdr_err_secs), 3);

    // R11: window alignment known here; fill to a boundary then test both directions
    base = m_idx;
    if (base != 0) good(BER_WIN - base);
    for (int i = 0; i < BER_WIN; i++)
      step(1'b1, mk((i < BER_THRESH) ? 2'b00 : 2'b01, 8'h00), 1'b0, 1'b0);
    chk("R11 high BER set", int'(hi_ber_o), 1);
    for (int i = 0; i < BER_WIN; i++)
      step(1'b1, mk((i < BER_THRESH - 1) ? 2'b11 : 2'b01, 8'h00), 1'b0, 1'b0);
    chk("R11 high BER cleared", int'(hi_ber_o), 0);

    // R7 and R9: empty windows count in both and saturate
    step(1'b0, 66'h0, 1'b1, 1'b0);
    for (int i = 0; i < CMAX + 3; i++) begin
      idle(2);
      step(1'b0, 66'h0, 1'b1, 1'b0);
      if (i == 0) chk("R7 empty window counted", int'(fmt_err_secs), m_cf);
    end
    chk("R9 header saturated", int'(hdr_err_secs), CMAX);
    chk("R9 format saturated", int'(fmt_err_secs), CMAX);

    // R10: clear wins over simultaneous tick
    step(1'b0, 66'h0, 1'b1, 1'b1);
    chk("R10 clear with tick", int'(hdr_err_secs) + int'(fmt_err_secs), 0);

    // random traffic
    for (int n = 0; n < 6000; n++) begin
      bit v, tk, cl;
      logic [1:0] sh;
      logic [7:0] ty;
      int r;
      v  = ($urandom_range(0, 9) < 8);
      r  = $urandom_range(0, 15);
      sh = (r == 0) ? 2'b00 : (r == 1) ? 2'b11 : (r < 6) ? 2'b10 : 2'b01;
      ty = ($urandom_range(0, 1) == 0) ? pick_code($urandom_range(0, 14)) : 8'($urandom);
      tk = ($urandom_range(0, 39) == 0);
      cl = ($urandom_range(0, 499) == 0);
      if ($urandom_range(0, 299) == 0) begin
        for (int k = 0; k < 30; k++) step(1'b0, mk(2'b11, 8'h00), (k == 29), 1'b0);
      end
      step(v, mk(sh, ty), tk, cl);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule